// File: doc/BRIEF.md
# Bit-Serial Normal-Basis Field Multiplier

This block multiplies two elements of the binary field GF(2^M), with M = 261 by default. Both operands are held in a type II optimal normal basis. The basis exists because 2M+1 = 523 is prime. The block produces the product one coefficient per clock. Each cycle both operand registers rotate cyclically by one position. A fixed combinational function then computes the next product coefficient and shifts it into the product register. That function is a set of two-input AND terms feeding a tree of three-input XOR gates, and its wiring is derived at elaboration time from the type II rule.

The same block also offers two single-cycle operations on the stored operands. Field addition is a bitwise XOR. Squaring is a cyclic rotation by one position, because of the normal-basis representation. A controller loads both operands while the block is idle and then issues one strobe. It watches `busy` and the one-cycle `done` pulse, and reads `result` once `done` is high.

Top module: `onb_mult`

## Requirements
- R1: While reset is held and in the cycle after it is released, `busy` is 0, `done` is 0 and `result` is all zeros.
- R2: When idle and no strobe is present, `load_a` / `load_b` write `a_in` / `b_in` into the stored operands at the clock edge. A load in the same cycle as an accepted strobe is discarded.
- R3: A multiply returns c with c_k = XOR over all (i, j) with L(i,j)=1 of a[(i+k) mod M] & b[(j+k) mod M]. Here L(i,j)=1 exactly when 2^i+2^j or 2^i-2^j is congruent to +1 or -1 modulo 2M+1. Bit k of `result` holds c_k.
- R4: An idle `start` makes `busy` rise at the next edge. `busy` stays high for exactly M cycles. `done` is high for exactly one cycle, the first cycle after `busy` falls, and is never high together with `busy`.
- R5: While `busy` is high, `start`, `sq_go`, `add_go`, `load_a` and `load_b` have no effect. The running product and the stored operands are unchanged by them.
- R6: An accepted `add_go` puts a XOR b on `result` and raises `done` at the next edge.
- R7: An accepted `sq_go` puts {a[M-2:0], a[M-1]} on `result` and raises `done` at the next edge. This value equals the multiply of a by itself.
- R8: Multiplying any element by the all-ones element returns that element, and multiplying by zero returns zero.
- R9: A multiply leaves the stored operands as they were, so a second `start` without reloading returns the same product.
- R10: When idle, strobes are accepted in the priority `start` over `sq_go` over `add_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_a | input | 1 | Write `a_in` into operand A when idle |
| load_b | input | 1 | Write `b_in` into operand B when idle |
| a_in | input | M | Operand A value, normal-basis coefficients |
| b_in | input | M | Operand B value, normal-basis coefficients |
| start | input | 1 | Begin a bit-serial multiply |
| sq_go | input | 1 | One-cycle square of operand A |
| add_go | input | 1 | One-cycle sum of A and B |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle pulse: `result` is valid |
| result | output | M | Product, square or sum |

## Verification
The assertions check the control behaviour on every cycle. They confirm that the `busy` window is exactly M cycles long, that `done` falls right on its edge and never overlaps `busy`, and that a start issued mid-run is not taken as a restart. They also confirm that the single-cycle add and square produce the XOR and the rotation of the stored operands. Only the bench scenarios can show that the serial product matches the normal-basis formula. The same goes for the all-ones and zero cases, square versus self-multiply, operand preservation across a run, and the discarding of loads given while busy or beside a strobe.

// File: rtl/onb_pkg.sv
// Package onb_pkg
// Elaboration-time helpers that derive the wiring of the type II optimal
// normal basis product function. Assumes 2*m+1 is prime and that the
// residues {+-2^j, j<m} cover every nonzero residue modulo 2*m+1.
package onb_pkg;

    // 2^e reduced modulo p
    function automatic int pow2mod(input int e, input int p);
        int r;
        r = 1;
        for (int k = 0; k < e; k++) r = (r * 2) % p;
        return r;
    endfunction

    // index j < m with 2^j congruent to +r or -r modulo p
    function automatic int res_index(input int r, input int m, input int p);
        int v;
        v = 1;
        for (int j = 0; j < m; j++) begin
            if (v == r || v == p - r) return j;
            v = (v * 2) % p;
        end
        return 0;
    endfunction

    // row (operand A index) of AND term k; term 0 is the lone term of row 0
    function automatic int term_row(input int k);
        return (k + 1) / 2;
    endfunction

    // column (operand B index) of AND term k
    function automatic int term_col(input int k, input int m, input int p);
        int x;
        if (k == 0) return 1;
        x = pow2mod(term_row(k), p);
        if (k % 2 == 1) return res_index((x + 1) % p, m, p);
        return res_index((x + p - 1) % p, m, p);
    endfunction

endpackage

// File: rtl/onb_xor3_tree.sv
// Module onb_xor3_tree
// Reduces N bits to their XOR using levels of three-input XOR gates. Each
// level zero-pads its input to a multiple of three and recurses until one
// bit remains. Purely combinational.
module onb_xor3_tree #(
    parameter int N = 3
) (
    input  logic [N-1:0] din,
    output logic         dout
);

    if (N == 1) begin : g_leaf
        assign dout = din[0];
    end else begin : g_node
        localparam int NO = (N + 2) / 3;
        localparam int W  = 3 * NO;

        logic [W-1:0]  padded;
        logic [NO-1:0] reduced;

        assign padded = W'(din);

        for (genvar k = 0; k < NO; k++) begin : g_x3
            assign reduced[k] = ^padded[3*k +: 3];
        end

        onb_xor3_tree #(.N(NO)) i_sub (
            .din  (reduced),
            .dout (dout)
        );
    end

endmodule

// File: rtl/onb_bit0.sv
// Module onb_bit0
// Fixed combinational function giving coefficient 0 of the normal-basis
// product of a and b. There are 2*M-1 two-input AND terms, wired from the
// type II rule at elaboration, feeding a three-input XOR tree. Assumes
// 2*M+1 is prime.
module onb_bit0 #(
    parameter int M = 261
) (
    input  logic [M-1:0] a,
    input  logic [M-1:0] b,
    output logic         c0
);
    import onb_pkg::*;

    localparam int P      = 2 * M + 1;
    localparam int NTERMS = 2 * M - 1;

    logic [NTERMS-1:0] terms;

    for (genvar k = 0; k < NTERMS; k++) begin : g_term
        localparam int ROW = term_row(k);
        localparam int COL = term_col(k, M, P);
        assign terms[k] = a[ROW] & b[COL];
    end

    onb_xor3_tree #(.N(NTERMS)) i_tree (
        .din  (terms),
        .dout (c0)
    );

endmodule

// File: rtl/onb_mult.sv
// Module onb_mult
// GF(2^M) arithmetic unit on type II optimal normal basis operands. It does
// a bit-serial multiply in M cycles, plus single-cycle square and add.
// Operands load only while idle. During a multiply both operands rotate one
// position per cycle and return to their loaded value after M steps.
// Synchronous active-low reset.
module onb_mult #(
    parameter int M = 261
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_a,
    input  logic         load_b,
    input  logic [M-1:0] a_in,
    input  logic [M-1:0] b_in,
    input  logic         start,
    input  logic         sq_go,
    input  logic         add_go,
    output logic         busy,
    output logic         done,
    output logic [M-1:0] result
);

    localparam int CW = $clog2(M);
    localparam logic [CW-1:0] LAST = CW'(M - 1);

    logic [M-1:0]  a_q;
    logic [M-1:0]  b_q;
    logic [M-1:0]  prod_q;
    logic [CW-1:0] step_q;
    logic          busy_q;
    logic          done_q;
    logic          next_bit;

    // product coefficient for the current rotation of the operands
    onb_bit0 #(.M(M)) i_bit0 (
        .a  (a_q),
        .b  (b_q),
        .c0 (next_bit)
    );

    // sequencing, operand storage and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            prod_q <= '0;
            step_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (busy_q) begin
                a_q    <= {a_q[0], a_q[M-1:1]};
                b_q    <= {b_q[0], b_q[M-1:1]};
                prod_q <= {next_bit, prod_q[M-1:1]};
                if (step_q == LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    step_q <= '0;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end else if (start) begin
                busy_q <= 1'b1;
                step_q <= '0;
            end else if (sq_go) begin
                prod_q <= {a_q[M-2:0], a_q[M-1]};
                done_q <= 1'b1;
            end else if (add_go) begin
                prod_q <= a_q ^ b_q;
                done_q <= 1'b1;
            end else begin
                if (load_a) a_q <= a_in;
                if (load_b) b_q <= b_in;
            end
        end
    end

    assign busy   = busy_q;
    assign done   = done_q;
    assign result = prod_q;

endmodule

// File: rtl/onb_mult_chk.sv
// Module onb_mult_chk
// Cycle-level properties of onb_mult: length of the busy window, the done
// pulse, start accepted only when idle, and the single-cycle add and square.
// Bound into every onb_mult instance below.
module onb_mult_chk #(
    parameter int M = 261
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         sq_go,
    input logic         add_go,
    input logic         busy,
    input logic         done,
    input logic [M-1:0] result,
    input logic [M-1:0] a_q,
    input logic [M-1:0] b_q
);

    logic [15:0] busy_len;

    // count consecutive busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1'b1;
        else           busy_len <= '0;
    end

    assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == 16'(M)));

    assert_done_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_no_done_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    assert_start_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && busy_len < 16'(M - 1)) |=> (busy && !done));

    assert_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && add_go && !start && !sq_go) |=> (done && result == $past(a_q ^ b_q)));

    assert_square_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sq_go && !start) |=> (done && result == {$past(a_q[M-2:0]), $past(a_q[M-1])}));

endmodule

bind onb_mult onb_mult_chk #(.M(M)) i_onb_mult_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .sq_go  (sq_go),
    .add_go (add_go),
    .busy   (busy),
    .done   (done),
    .result (result),
    .a_q    (a_q),
    .b_q    (b_q)
);

// File: tb/test_onb_mult.sv
// Bench for onb_mult: seeded random and directed operands, checked against
// a bench model of the type II normal-basis product.
module test_onb_mult;

    localparam int M = 261;
    localparam int P = 2 * M + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_a = 1'b0, load_b = 1'b0;
    logic [M-1:0] a_in = '0, b_in = '0;
    logic         start = 1'b0, sq_go = 1'b0, add_go = 1'b0;
    logic         busy, done;
    logic [M-1:0] result;

    int checks = 0;
    int errors = 0;
    int pw [M];
    int pa [M];
    int pb [M];

    always #2 clk = ~clk;

    onb_mult #(.M(M)) i_onb_mult (
        .clk(clk), .rst_n(rst_n), .load_a(load_a), .load_b(load_b),
        .a_in(a_in), .b_in(b_in), .start(start), .sq_go(sq_go),
        .add_go(add_go), .busy(busy), .done(done), .result(result)
    );

    task automatic chk(input bit ok, input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [M-1:0] rnd();
        logic [M-1:0] v;
        v = '0;
        for (int w = 0; w < (M + 31) / 32; w++) v = (v << 32) | M'($urandom());
        return v;
    endfunction

    function automatic logic [M-1:0] rot_up(input logic [M-1:0] v);
        return {v[M-2:0], v[M-1]};
    endfunction

    // normal-basis product from the partner table of the rule in R3
    function automatic logic [M-1:0] model_mul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] c;
        c = '0;
        for (int k = 0; k < M; k++)
            for (int i = 0; i < M; i++) begin
                if (pa[i] >= 0) c[k] = c[k] ^ (a[(i + k) % M] & b[(pa[i] + k) % M]);
                if (pb[i] >= 0) c[k] = c[k] ^ (a[(i + k) % M] & b[(pb[i] + k) % M]);
            end
        return c;
    endfunction

    task automatic load(input logic [M-1:0] a, input logic [M-1:0] b);
        @(negedge clk);
        a_in = a; b_in = b; load_a = 1'b1; load_b = 1'b1;
        @(negedge clk);
        load_a = 1'b0; load_b = 1'b0;
    endtask

    // wait for done after a start already taken; returns busy length
    task automatic wait_done(output int len);
        len = 0;
        while (!done && len < 3 * M) begin
            @(posedge clk); #1;
            len++;
        end
    endtask

    task automatic run_mult(output logic [M-1:0] res, output int len);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done(len);
        res = result;
        @(posedge clk); #1;
        chk(!done, "R4 done one cycle", M'(done), '0);
    endtask

    task automatic run_single(input bit sq, input bit ad, output logic [M-1:0] res);
        @(negedge clk); sq_go = sq; add_go = ad;
        @(negedge clk); sq_go = 1'b0; add_go = 1'b0;
        chk(done == 1'b1 && busy == 1'b0, "R6/R7 done after single op", M'(done), M'(1));
        res = result;
    endtask

    task automatic mult_check(input logic [M-1:0] a, input logic [M-1:0] b, input string req);
        logic [M-1:0] res, exp;
        int len;
        load(a, b);
        exp = model_mul(a, b);
        run_mult(res, len);
        chk(res == exp, req, res, exp);
        chk(len == M, "R4 busy length", M'(len), M'(M));
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [M-1:0] a, b, res, res2, exp, ones;
        int len, s, d;
        void'($urandom(32'd20240611));
        ones = '1;
        for (int i = 0; i < M; i++) pw[i] = (i == 0) ? 1 : (pw[i-1] * 2) % P;
        for (int i = 0; i < M; i++) begin
            pa[i] = -1; pb[i] = -1;
            for (int j = 0; j < M; j++) begin
                s = (pw[i] + pw[j]) % P;
                d = (pw[i] - pw[j] + P) % P;
                if (s == 1 || s == P - 1 || d == 1 || d == P - 1) begin
                    if (pa[i] < 0) pa[i] = j; else pb[i] = j;
                end
            end
        end

        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && result == '0, "R1 in reset", result, '0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(busy == 0 && done == 0 && result == '0, "R1 after reset", result, '0);

        // identity and zero
        a = rnd();
        mult_check(a, ones, "R3 model a*ones");
        load(a, ones); run_mult(res, len);
        chk(res == a, "R8 a*ones == a", res, a);
        load(ones, a); run_mult(res, len);
        chk(res == a, "R8 ones*a == a", res, a);
        load(a, '0); run_mult(res, len);
        chk(res == '0, "R8 a*zero == 0", res, '0);
        load(ones, ones); run_mult(res, len);
        chk(res == ones, "R8 ones*ones", res, ones);

        // random products
        for (int t = 0; t < 8; t++) begin
            a = rnd(); b = rnd();
            mult_check(a, b, "R3 random product");
        end
        a = M'(1); b = rnd();
        mult_check(a, b, "R3 single basis element");

        // operands preserved
        a = rnd(); b = rnd(); exp = model_mul(a, b);
        load(a, b);
        run_mult(res, len);
        run_mult(res2, len);
        chk(res2 == exp, "R9 second start same product", res2, exp);
        run_single(1'b0, 1'b1, res);
        chk(res == (a ^ b), "R9 operands intact after multiply", res, a ^ b);

        // add and square
        a = rnd(); b = rnd();
        load(a, b);
        run_single(1'b0, 1'b1, res);
        chk(res == (a ^ b), "R6 add", res, a ^ b);
        chk(res == (a ^ b), "R2 load visible via add", res, a ^ b);
        run_single(1'b1, 1'b0, res);
        chk(res == rot_up(a), "R7 square is rotation", res, rot_up(a));
        exp = model_mul(a, a);
        chk(res == exp, "R7 square equals a*a", res, exp);
        load(a, a); run_mult(res2, len);
        chk(res2 == res, "R7 hardware a*a equals square", res2, res);

        // interference during busy
        a = rnd(); b = rnd(); exp = model_mul(a, b);
        load(a, b);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (40) @(negedge clk);
        a_in = rnd(); b_in = rnd(); load_a = 1'b1; load_b = 1'b1;
        start = 1'b1; sq_go = 1'b1; add_go = 1'b1;
        @(negedge clk);
        load_a = 1'b0; load_b = 1'b0; start = 1'b0; sq_go = 1'b0; add_go = 1'b0;
        wait_done(len);
        chk(result == exp, "R5 product unaffected by busy inputs", result, exp);
        chk(len == M - 41, "R5 no restart during busy", M'(len), M'(M - 41));
        @(negedge clk);
        run_single(1'b0, 1'b1, res);
        chk(res == (a ^ b), "R5 loads ignored while busy", res, a ^ b);

        // priority
        @(negedge clk); start = 1'b1; sq_go = 1'b1; add_go = 1'b1;
        @(negedge clk); start = 1'b0; sq_go = 1'b0; add_go = 1'b0;
        chk(busy == 1'b1, "R10 start wins", M'(busy), M'(1));
        wait_done(len);
        chk(result == exp, "R10 start product", result, exp);
        run_single(1'b1, 1'b1, res);
        chk(res == rot_up(a), "R10 square over add", res, rot_up(a));

        // load beside a strobe is dropped
        @(negedge clk); a_in = rnd(); load_a = 1'b1; add_go = 1'b1;
        @(negedge clk); load_a = 1'b0; add_go = 1'b0;
        chk(result == (a ^ b), "R2 add uses old operand", result, a ^ b);
        run_single(1'b0, 1'b1, res);
        chk(res == (a ^ b), "R2 load with strobe discarded", res, a ^ b);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule